// File: doc/BRIEF.md
# Jack-Detect Output Switch Controller

This block uses a jack-detect input pin to choose between two audio output paths: a speaker path and a mono path. The raw pin is brought into the master-clock domain through a two-flop synchroniser. Its sense can then be inverted by a polarity bit. The result is debounced on a slow tick made by dividing the master clock by 2^DIV_LOG2, which is 2^21 by default. The debounced detect state steers the speaker and mono enables.

The pin acts as a switch only when the pin-function select field holds the jack-switch code and the device is in two-wire control mode. In that mode the chip-select pin is free to act as a general input. Steering also needs both output enable bits to be set. Otherwise each output simply follows its own enable bit.

Top module: `jack_switch_top`

## Requirements
- R1: Steering is active only when `func_sel_i` equals 3'b001 and `two_wire_i` is 1. When it is inactive, `spk_en_o` equals `spk_en_i` and `mono_en_o` equals `mono_en_i`.
- R2: When `pol_i` is 1, the synchronised pin is inverted before it is debounced. A low pin then counts as detect asserted.
- R3: With steering active and both enable bits set, `det_o`=1 gives `spk_en_o`=0 and `mono_en_o`=1. `det_o`=0 gives `spk_en_o`=1 and `mono_en_o`=0.
- R4: When either `spk_en_i` or `mono_en_i` is 0, each output equals its own enable bit, whatever the value of `det_o`.
- R5: The divider counts only while steering is active and `slow_en_i` is 1. It produces one tick every 2^DIV_LOG2 master-clock cycles. `det_o` can change only on the clock edge that ends a tick cycle.
- R6: While `slow_en_i` is 0, or while steering is inactive, no tick is produced, `det_o` holds its value and the divider counter is held at zero.
- R7: `det_o` takes a new level only after two consecutive tick samples both show that level. A single differing sample is ignored.
- R8: After synchronous reset `det_o` is 0 and the divider counter is 0.
- R9: A pin change reaches the debouncer after two master-clock flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw jack-detect pin |
| func_sel_i | input | 3 | Pin-function select; 3'b001 selects the jack switch |
| pol_i | input | 1 | Pin polarity invert |
| slow_en_i | input | 1 | Slow debounce clock enable |
| two_wire_i | input | 1 | 1 when the device uses the two-wire control interface |
| spk_en_i | input | 1 | Speaker path enable bit |
| mono_en_i | input | 1 | Mono path enable bit |
| spk_en_o | output | 1 | Effective speaker enable |
| mono_en_o | output | 1 | Effective mono enable |
| det_o | output | 1 | Debounced detect state |

## Verification
The assertions assume that configuration inputs change only between clock edges and are otherwise static register values. They also assume the pin is a level that the synchroniser may sample at any edge. The bench follows this: it drives every input just after the falling edge and compares every output with its model at the next falling edge. The divider width is shortened so that many ticks fit in a run. Glitches are kept shorter than one tick period, so each glitch can spoil at most one sample.

// File: rtl/jack_switch_pkg.sv
package jack_switch_pkg;

    localparam logic [2:0] FUNC_JACK_SWITCH = 3'b001;

    typedef struct packed {
        logic [2:0] func_sel;
        logic       pol;
        logic       slow_en;
        logic       two_wire;
        logic       spk_en;
        logic       mono_en;
    } sw_cfg_t;

    typedef struct packed {
        logic spk;
        logic mono;
    } path_en_t;

    function automatic logic steer_active(input sw_cfg_t c);
        return (c.func_sel == FUNC_JACK_SWITCH) && c.two_wire;
    endfunction

    function automatic path_en_t route_paths(input sw_cfg_t c, input logic det);
        path_en_t r;
        if (steer_active(c) && c.spk_en && c.mono_en) begin
            r.spk  = ~det;
            r.mono = det;
        end else begin
            r.spk  = c.spk_en;
            r.mono = c.mono_en;
        end
        return r;
    endfunction

endpackage

// File: rtl/jack_pin_sync.sv
module jack_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/jack_slow_tick.sv
module jack_slow_tick #(
    parameter int DIV_LOG2 = 21
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam logic [DIV_LOG2-1:0] LAST = '1;

    logic [DIV_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);

    // R6: an idle divider sits at zero
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> cnt_q == '0);
    // R5: the counter wraps right after a tick
    assert_wrap_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
        tick_o && run_i |=> cnt_q == '0);
endmodule

// File: rtl/jack_debounce.sv
module jack_debounce (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sample_i,
    output logic det_o
);
    logic state_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (tick_i) begin
            last_q <= sample_i;
            if (sample_i != state_q && last_q == sample_i)
                state_q <= sample_i;
        end
    end

    assign det_o = state_q;

    // R5: without a tick the state is frozen
    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(det_o));
    // R7: a lone differing sample does not flip the state
    assert_lone_sample_R7: assert property (@(posedge clk) disable iff (rst)
        tick_i && sample_i != det_o && last_q != sample_i |=> $stable(det_o));
endmodule

// File: rtl/jack_switch_top.sv
module jack_switch_top
    import jack_switch_pkg::*;
#(
    parameter int DIV_LOG2 = 21
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  logic [2:0] func_sel_i,
    input  logic       pol_i,
    input  logic       slow_en_i,
    input  logic       two_wire_i,
    input  logic       spk_en_i,
    input  logic       mono_en_i,
    output logic       spk_en_o,
    output logic       mono_en_o,
    output logic       det_o
);
    sw_cfg_t  cfg;
    path_en_t paths;
    logic     pin_sync;
    logic     sample;
    logic     run;
    logic     tick;
    logic     det;

    assign cfg = '{func_sel: func_sel_i, pol: pol_i, slow_en: slow_en_i,
                   two_wire: two_wire_i, spk_en: spk_en_i, mono_en: mono_en_i};

    jack_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_sync)
    );

    assign sample = pin_sync ^ cfg.pol;
    assign run    = steer_active(cfg) && cfg.slow_en;

    jack_slow_tick #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk(clk), .rst(rst), .run_i(run), .tick_o(tick)
    );

    jack_debounce u_deb (
        .clk(clk), .rst(rst), .tick_i(tick), .sample_i(sample), .det_o(det)
    );

    assign paths     = route_paths(cfg, det);
    assign spk_en_o  = paths.spk;
    assign mono_en_o = paths.mono;
    assign det_o     = det;

    // R3: exactly one path is on while steering with both enables set
    assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        steer_active(cfg) && spk_en_i && mono_en_i |-> spk_en_o != mono_en_o);
    // R4: a cleared enable bit turns its output off
    assert_clear_bit_off_R4: assert property (@(posedge clk) disable iff (rst)
        !(spk_en_i && mono_en_i) |-> spk_en_o == spk_en_i && mono_en_o == mono_en_i);
    // R1: no steering when the pin is not in switch mode
    assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
        !steer_active(cfg) |-> spk_en_o == spk_en_i && mono_en_o == mono_en_i);
    // R6: no detect change while the slow clock is off
    assert_hold_slow_off_R6: assert property (@(posedge clk) disable iff (rst)
        !slow_en_i |=> $stable(det_o));
endmodule

// File: tb/test_jack_switch_top.sv
module test_jack_switch_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int WRAP       = 1 << DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_i = 1'b0;
    logic [2:0] func_sel_i = 3'b001;
    logic       pol_i = 1'b0;
    logic       slow_en_i = 1'b1;
    logic       two_wire_i = 1'b1;
    logic       spk_en_i = 1'b1;
    logic       mono_en_i = 1'b1;
    logic       spk_en_o, mono_en_o, det_o;

    int total = 0;
    int bad = 0;
    string req = "R8";

    // behavioural model state
    int m_s1 = 0, m_s2 = 0, m_cnt = 0, m_det = 0, m_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jack_switch_top #(.DIV_LOG2(DIV)) i_jack_switch_top (
        .clk(clk), .rst(rst), .pin_i(pin_i), .func_sel_i(func_sel_i),
        .pol_i(pol_i), .slow_en_i(slow_en_i), .two_wire_i(two_wire_i),
        .spk_en_i(spk_en_i), .mono_en_i(mono_en_i),
        .spk_en_o(spk_en_o), .mono_en_o(mono_en_o), .det_o(det_o)
    );

    always @(posedge clk) begin
        int steer, adv, smp;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_cnt = 0; m_det = 0; m_last = 0;
        end else begin
            steer = (func_sel_i == 3'b001 && two_wire_i) ? 1 : 0;
            adv   = steer && slow_en_i;
            smp   = m_s2 ^ int'(pol_i);
            if (adv && m_cnt == WRAP - 1) begin
                if (smp != m_det && m_last == smp) m_det = smp;
                m_last = smp;
            end
            m_cnt = adv ? (m_cnt + 1) % WRAP : 0;
            m_s2  = m_s1;
            m_s1  = int'(pin_i);
        end
    end

    task automatic check(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int e_spk, e_mono;
        if (!rst) begin
            if (func_sel_i == 3'b001 && two_wire_i && spk_en_i && mono_en_i) begin
                e_spk = 1 - m_det; e_mono = m_det;
            end else begin
                e_spk = int'(spk_en_i); e_mono = int'(mono_en_i);
            end
            check("det", int'(det_o), m_det);
            check("spk", int'(spk_en_o), e_spk);
            check("mono", int'(mono_en_o), e_mono);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        req = "R8";
        check("reset det", int'(det_o), 0);
        check("reset spk", int'(spk_en_o), 1);
        check("reset mono", int'(mono_en_o), 0);
        step(2);
        // R3 R5 R9: assert the pin and hold it past two ticks
        req = "R3";
        pin_i = 1'b1;
        step(5 * WRAP);
        check("det after insert R5", int'(det_o), 1);
        check("spk off R3", int'(spk_en_o), 0);
        // R7: a glitch shorter than one tick is ignored
        req = "R7";
        pin_i = 1'b0;
        step(WRAP - 3);
        pin_i = 1'b1;
        step(3 * WRAP);
        check("det after glitch R7", int'(det_o), 1);
        // R2: invert polarity; a high pin now reads as removed
        req = "R2";
        pol_i = 1'b1;
        step(4 * WRAP);
        check("det polarity R2", int'(det_o), 0);
        pin_i = 1'b0;
        step(4 * WRAP);
        check("det low pin R2", int'(det_o), 1);
        // R6: slow clock off freezes the state
        req = "R6";
        slow_en_i = 1'b0;
        pin_i = 1'b1;
        step(5 * WRAP);
        check("det frozen R6", int'(det_o), 1);
        slow_en_i = 1'b1;
        step(4 * WRAP);
        // R1: other pin functions and four-wire mode pass enables through
        req = "R1";
        func_sel_i = 3'b010;
        pin_i = 1'b0;
        step(4 * WRAP);
        check("spk passthru R1", int'(spk_en_o), 1);
        check("mono passthru R1", int'(mono_en_o), 1);
        func_sel_i = 3'b001;
        two_wire_i = 1'b0;
        step(4 * WRAP);
        check("spk four-wire R1", int'(spk_en_o), 1);
        two_wire_i = 1'b1;
        step(4 * WRAP);
        // R4: a cleared enable disables steering for both outputs
        req = "R4";
        for (int k = 0; k < 4; k++) begin
            spk_en_i  = k[0];
            mono_en_i = k[1];
            pin_i     = ~pin_i;
            step(3 * WRAP);
        end
        spk_en_i = 1'b1;
        mono_en_i = 1'b1;
        // R5 R9: pseudo-random pin activity across many ticks
        req = "R5";
        for (int k = 0; k < 300; k++) begin
            pin_i = ((k * 37 + k / 5) % 7) < 3;
            if (k % 50 == 7) pol_i = ~pol_i;
            step(1 + (k % 11));
        end
        req = "R9";
        pin_i = ~pin_i;
        step(6 * WRAP);
        step(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule